// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is handed over with a valid/ready handshake. Alongside it come control fields that select a character length of five to eight bits, whether a parity bit is added, its sense (even, odd or forced constant) and whether the frame ends with one stop bit or a longer one. The line idles high. Each frame opens with a low start bit, sends the data least significant bit first, then the optional parity bit, then the stop period.

Bit timing comes from an external enable that pulses at sixteen times the bit rate. Every bit lasts sixteen of these pulses. A half stop bit lasts eight, which gives one and a half stop bits for five-bit characters. A separate break input pulls the output low at once. The frame sequencing underneath keeps running, so the busy flag and the bit timing are the same with or without break.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_busy` is 0, `in_ready` is 1 and `tx_out` is 1 (with break clear).
- R2: A character is taken on a clock edge where `in_valid` and `in_ready` are both 1. `tx_busy` is 1 from the next cycle on, and `in_ready` equals the inverse of `tx_busy`. `in_valid` asserted while busy is ignored and does not change the frame in flight.
- R3: A frame starts with a start bit of 0 in the cycle after the load. Data bits follow least significant bit first. Every start, data and parity bit lasts exactly 16 `baud_tick` pulses.
- R4: `cfg_len` selects the number of data bits: 2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8. Data bits above the selected length are not sent.
- R5: With `cfg_par_en` = 1, one parity bit follows the last data bit and precedes the stop period. With `cfg_par_en` = 0, the stop period follows the last data bit directly.
- R6: With parity enabled and stick clear, `cfg_par_even` = 1 makes the sent data bits plus parity hold an even count of ones. `cfg_par_even` = 0 makes the count odd.
- R7: With parity enabled and `cfg_par_stick` = 1, the parity bit is 0 when `cfg_par_even` = 1 and 1 when `cfg_par_even` = 0, whatever the data.
- R8: The stop period drives 1. It lasts 16 ticks when `cfg_stop_long` = 0, 24 ticks when `cfg_stop_long` = 1 with a 5-bit length, and 32 ticks when `cfg_stop_long` = 1 with a 6, 7 or 8-bit length. `tx_busy` falls on the clock edge that takes the last stop tick.
- R9: While `cfg_break` = 1, `tx_out` is 0 in the same cycle. The break has no effect on `tx_busy` or on the bit timing of the frame.
- R10: The length, parity and stop fields are sampled at the load. Changing them during a frame has no effect on that frame.
- R11: The unbroken line value changes only on a clock edge that takes a `baud_tick` or loads a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| in_valid | input | 1 | Character on `in_data` is offered |
| in_ready | output | 1 | Block can take a character (not busy) |
| in_data | input | 8 | Character to send, bit 0 sent first |
| cfg_len | input | 2 | Data bit count select (5 to 8) |
| cfg_par_en | input | 1 | Add a parity bit |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_par_stick | input | 1 | Force the parity bit to a constant |
| cfg_stop_long | input | 1 | Long stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the serial output low |
| tx_out | output | 1 | Serial output line |
| tx_busy | output | 1 | A frame is in progress |

## Verification
On every cycle, the assertions check the handshake rules: a load raises busy, and busy rises only after a valid. They also check that the start bit goes low right after a load, that the idle line stays high, that the frame settings stay frozen during a frame, that the line moves only on ticks or loads, and that the bit counter stays inside the current phase length. Only the bench scenarios can show the bit order, the parity values for each length and sense, the exact length of each stop period, and that break and mid-frame control changes leave the frame's content and timing intact. They do so by sampling the middle of every bit against a frame built independently, and by checking busy one tick before and at the end of the stop period.

// File: rtl/uart_tx_pkg.sv
// Shared types and helpers of the serial frame transmitter.
// Assumes at most 8 data bits, selected through a 2-bit length code.
package uart_tx_pkg;

    localparam int MAX_BITS = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
        logic       stop_long;
    } frame_cfg_t;

    // Number of ticks in the stop period for a given setting.
    function automatic int stop_ticks(input logic [1:0] len, input logic stop_long,
                                      input int oversample);
        if (!stop_long)
            return oversample;
        else if (len == 2'b00)
            return oversample + oversample / 2;
        else
            return 2 * oversample;
    endfunction

endpackage

// File: rtl/uart_tx_bit_timer.sv
// Tick counter for one frame phase: counts baud enables and flags the
// tick that completes a phase of 'limit' ticks. Assumes limit >= 1 and
// that limit only changes in the cycle after done or clear.
module uart_tx_bit_timer #(
    parameter int TICK_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clear,
    input  logic              tick,
    input  logic [TICK_W-1:0] limit,
    output logic              done
);

    logic [TICK_W-1:0] cnt_q;
    logic              at_end;

    assign at_end = (cnt_q == limit - TICK_W'(1));
    assign done   = run && tick && at_end;

    // Advance on every tick, wrap at the phase end, hold zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= at_end ? '0 : cnt_q + TICK_W'(1);
    end

    // R3: the count never exceeds the length of the active phase
    assert_cnt_in_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/uart_tx_parity_gen.sv
// Parity bit generator: masks the data to the selected length and forms
// even, odd or stick parity. Purely combinational; the caller decides
// whether the bit is sent at all.
module uart_tx_parity_gen
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = MAX_BITS
) (
    input  logic [DATA_W-1:0] data,
    input  frame_cfg_t        cfg,
    output logic              par_bit
);

    logic [3:0]        nbits;
    logic [DATA_W-1:0] masked;
    logic              ones_odd;

    assign nbits = 4'(MIN_BITS) + {2'b00, cfg.len};

    // Keep only the bits that are part of the character.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] && (4'(i) < nbits);
    end

    assign ones_odd = ^masked;

    // Choose the constant bit for stick parity, else balance the count of ones.
    always_comb begin
        if (cfg.par_stick)
            par_bit = !cfg.par_even;
        else if (cfg.par_even)
            par_bit = ones_odd;
        else
            par_bit = !ones_odd;
    end

endmodule

// File: rtl/uart_frame_tx.sv
// Serial frame transmitter top: takes one character through a
// valid/ready handshake, latches the frame settings and sends start,
// data (LSB first), optional parity and the stop period. Timing comes
// from a 16x baud enable. Break forces the pin low without touching
// the sequencing.
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                baud_tick,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [MAX_BITS-1:0] in_data,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_even,
    input  logic                cfg_par_stick,
    input  logic                cfg_stop_long,
    input  logic                cfg_break,
    output logic                tx_out,
    output logic                tx_busy
);

    localparam int TICK_W = $clog2(2 * OVERSAMPLE + 1);
    localparam int IDX_W  = $clog2(MAX_BITS);

    tx_state_e           state_q;
    frame_cfg_t          cfg_in, cfg_q;
    logic [MAX_BITS-1:0] shreg_q;
    logic [IDX_W-1:0]    idx_q, last_idx;
    logic                line_q, par_q, par_new;
    logic                accept, phase_done;
    logic [TICK_W-1:0]   phase_limit;

    assign cfg_in   = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                        par_stick: cfg_par_stick, stop_long: cfg_stop_long};
    assign tx_busy  = (state_q != ST_IDLE);
    assign in_ready = !tx_busy;
    assign accept   = in_valid && in_ready;
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.len);
    assign tx_out   = cfg_break ? 1'b0 : line_q;

    // Phase length: one bit period, or the stop period chosen at load.
    assign phase_limit = (state_q == ST_STOP)
        ? TICK_W'(stop_ticks(cfg_q.len, cfg_q.stop_long, OVERSAMPLE))
        : TICK_W'(OVERSAMPLE);

    uart_tx_parity_gen #(.DATA_W(MAX_BITS)) u_parity (
        .data    (in_data),
        .cfg     (cfg_in),
        .par_bit (par_new)
    );

    uart_tx_bit_timer #(.TICK_W(TICK_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tx_busy),
        .clear (accept),
        .tick  (baud_tick),
        .limit (phase_limit),
        .done  (phase_done)
    );

    // Frame sequencer: load, then step through the phases on each phase end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cfg_q   <= '0;
            shreg_q <= '0;
            idx_q   <= '0;
            line_q  <= 1'b1;
            par_q   <= 1'b0;
        end else if (accept) begin
            state_q <= ST_START;
            cfg_q   <= cfg_in;
            shreg_q <= in_data;
            idx_q   <= '0;
            line_q  <= 1'b0;
            par_q   <= par_new;
        end else if (phase_done) begin
            case (state_q)
                ST_START: begin
                    state_q <= ST_DATA;
                    line_q  <= shreg_q[0];
                end
                ST_DATA: begin
                    if (idx_q == last_idx) begin
                        state_q <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                        line_q  <= cfg_q.par_en ? par_q : 1'b1;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        shreg_q <= shreg_q >> 1;
                        line_q  <= shreg_q[1];
                    end
                end
                ST_PARITY: begin
                    state_q <= ST_STOP;
                    line_q  <= 1'b1;
                end
                default: begin
                    state_q <= ST_IDLE;
                    line_q  <= 1'b1;
                end
            endcase
        end
    end

    // R2: a taken character makes the block busy in the next cycle
    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> tx_busy);

    // R2: busy never starts without an offered character
    assert_busy_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(in_valid));

    // R3: the first cycle of a frame shows the start bit
    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) && !cfg_break |-> !tx_out);

    // R1: an idle, unbroken line stays at mark
    assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy && !cfg_break |-> tx_out);

    // R10: frame settings stay frozen while a frame runs
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy && $past(tx_busy) |-> $stable(cfg_q));

    // R11: the line value moves only on a tick or a load
    assert_line_on_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_q) |-> $past(baud_tick) || $past(accept));

endmodule

// File: tb/tb_uart_frame_tx.sv
`timescale 1ns/1ps
// Bench: directed corner frames plus seeded random frames, each compared
// bit by bit against a frame built by bench functions.
module tb_uart_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n, baud_tick, in_valid, in_ready;
    logic [7:0] in_data;
    logic [1:0] cfg_len;
    logic       cfg_par_en, cfg_par_even, cfg_par_stick, cfg_stop_long, cfg_break;
    logic       tx_out, tx_busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .cfg_len(cfg_len),
        .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
        .cfg_par_stick(cfg_par_stick), .cfg_stop_long(cfg_stop_long),
        .cfg_break(cfg_break), .tx_out(tx_out), .tx_busy(tx_busy)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_parity(input logic [7:0] d, input logic [1:0] len,
                                        input logic even, input logic stick);
        logic ones = 1'b0;
        for (int i = 0; i < 5 + int'(len); i++) ones ^= d[i];
        if (stick) return !even;
        return even ? ones : !ones;
    endfunction

    function automatic int exp_stop(input logic [1:0] len, input logic long_stop);
        if (!long_stop) return 16;
        return (len == 2'b00) ? 24 : 32;
    endfunction

    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic run_frame(input logic [7:0] d, input logic [1:0] len, input logic pe,
                             input logic ev, input logic st, input logic sl,
                             input bit do_break, input bit do_poke);
        logic seq [0:11];
        int   n, stp;
        string tag;
        seq[0] = 1'b0;
        for (int i = 0; i < 5 + int'(len); i++) seq[1 + i] = d[i];
        n = 6 + int'(len);
        if (pe) begin
            seq[n] = exp_parity(d, len, ev, st);
            n++;
        end
        stp = exp_stop(len, sl);

        @(negedge clk);
        check("R2 ready before load", in_ready, 1);
        in_valid = 1'b1; in_data = d; cfg_len = len; cfg_par_en = pe;
        cfg_par_even = ev; cfg_par_stick = st; cfg_stop_long = sl;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 busy after load", tx_busy, 1);
        check("R3 start bit right after load", tx_out, 0);
        // R10: scramble the settings for the rest of the frame
        cfg_len = 2'($urandom); cfg_par_en = 1'($urandom); cfg_par_even = 1'($urandom);
        cfg_par_stick = 1'($urandom); cfg_stop_long = 1'($urandom);
        in_data = 8'($urandom);

        for (int b = 0; b < n; b++) begin
            for (int t = 1; t <= 16; t++) begin
                tick();
                if (t == 8) begin
                    if (b == 0) tag = "R3 start";
                    else if (b < 6 + int'(len)) tag = "R4/R10 data bit";
                    else tag = st ? "R7 stick parity" : "R6 parity";
                    check(tag, tx_out, seq[b]);
                    repeat (2) @(negedge clk);
                    check("R11 line steady without tick", tx_out, seq[b]);
                end
                if (do_poke && b == 1 && t == 4) begin
                    check("R2 not ready while busy", in_ready, 0);
                    in_valid = 1'b1; in_data = ~d;
                    @(negedge clk) in_valid = 1'b0;
                end
                if (do_break && b == 2 && t == 9) begin
                    cfg_break = 1'b1;
                    @(negedge clk);
                    check("R9 break forces low", tx_out, 0);
                    check("R9 break keeps busy", tx_busy, 1);
                    cfg_break = 1'b0;
                end
            end
        end
        for (int t = 1; t <= stp; t++) begin
            tick();
            if (t == 8) check(pe ? "R8 stop level" : "R5 stop right after data", tx_out, 1);
            if (t == stp - 1) check("R8/R10 busy before last stop tick", tx_busy, 1);
            if (t == stp) begin
                check("R8/R10 busy ends on last stop tick", tx_busy, 0);
                check("R1 ready after frame", in_ready, 1);
                check("R1 idle mark after frame", tx_out, 1);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7351));
        rst_n = 1'b0; baud_tick = 1'b0; in_valid = 1'b0; in_data = '0;
        cfg_len = '0; cfg_par_en = 0; cfg_par_even = 0; cfg_par_stick = 0;
        cfg_stop_long = 0; cfg_break = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset busy", tx_busy, 0);
        check("R1 reset ready", in_ready, 1);
        check("R1 reset line", tx_out, 1);

        // R9: break while idle pulls the line low, busy unchanged
        cfg_break = 1'b1;
        @(negedge clk);
        check("R9 idle break low", tx_out, 0);
        check("R9 idle break not busy", tx_busy, 0);
        cfg_break = 1'b0;

        // R4/R8: every length with both stop settings, no parity (R5)
        for (int l = 0; l < 4; l++) begin
            run_frame(8'hB5, 2'(l), 0, 0, 0, 0, 0, 0);
            run_frame(8'h6A, 2'(l), 0, 0, 0, 1, 0, 0);
        end
        // R6: even and odd parity with odd and even data weights
        run_frame(8'h07, 2'b00, 1, 1, 0, 0, 0, 0);
        run_frame(8'h07, 2'b00, 1, 0, 0, 0, 0, 0);
        run_frame(8'hFF, 2'b11, 1, 1, 0, 1, 0, 0);
        run_frame(8'hE1, 2'b01, 1, 0, 0, 1, 0, 0);
        // R7: stick parity in both senses
        run_frame(8'h01, 2'b11, 1, 0, 1, 0, 0, 0);
        run_frame(8'h01, 2'b11, 1, 1, 1, 0, 0, 0);
        // R9 mid-frame break and R2 ignored offer while busy
        run_frame(8'h5A, 2'b10, 1, 1, 0, 1, 1, 1);
        run_frame(8'h13, 2'b00, 1, 0, 1, 1, 1, 1);

        for (int k = 0; k < 40; k++)
            run_frame(8'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                      1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule